// File: doc/BRIEF.md
# Video Line Clamp Pulse Generator

This block makes one clamp window per video line. It times the window in pixel clocks from the trailing (falling) edge of horizontal sync. A programmable placement delay comes first, then a programmable duration. Instead of the internal window, the block can pass an external clamp input through to the output. The polarity of that input is either set by configuration or inferred from the level the input rests at.

A second output is a one-cycle offset-update strobe for the downstream auto-offset loop. It fires at the end of a clamp window, at a selectable rate: every window, every 16th window, every 64th window, or the first window after each rising edge of vertical sync.

All sync and clamp inputs are treated as asynchronous and pass through two-flop synchronizers. Configuration inputs are expected to come from a register bank. The recommended defaults are held in the package: placement 8, duration 32, polarity bit 1, rate 11, offset enable 0.

Top module: `line_clamp_gen`

## Requirements
- R1: With the internal source selected, label as edge 0 the first rising clock edge at which `hsync_in` is sampled low after being high. `clamp_out` goes high after edge `cfg_place + 3`.
- R2: The internal clamp window stays high for exactly `cfg_dur` clock cycles.
- R3: When `cfg_dur` is 0, no clamp window and no offset strobe are produced for that line.
- R4: A new hsync trailing edge during placement or duration restarts the placement count from that edge, ending any clamp already active.
- R5: With `cfg_src_ext` = 1, `clamp_out` follows the polarity-corrected `ext_clamp_in`, and a change sampled at edge 0 appears after edge 2.
- R6: With `cfg_pol_ovr` = 1, `cfg_pol_high` = 1 treats a high external input as active and 0 treats a low one as active.
- R7: With `cfg_pol_ovr` = 0, the idle level after reset is low, so high is active. Once the external input holds one level for `IDLE_RUN` (default 512) consecutive synchronized samples, that level becomes idle and the opposite level becomes active.
- R8: With `cfg_ofs_en` = 0, `ofs_strobe` stays low and the window counter and the vsync arm are cleared.
- R9: `ofs_strobe` is one cycle wide. It is high in the first cycle in which `clamp_out` is low after a window.
- R10: `cfg_ofs_rate` = 00 gives a strobe after every clamp window.
- R11: `cfg_ofs_rate` = 01 gives a strobe after every 16th window and 10 after every 64th, counted from when the strobe is enabled.
- R12: `cfg_ofs_rate` = 11 gives a strobe only at the end of the first window after a rising edge of `vsync_in`.
- R13: During and right after reset, `clamp_out` and `ofs_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_in | input | 1 | Horizontal sync, active high, asynchronous |
| vsync_in | input | 1 | Vertical sync, active high, asynchronous |
| ext_clamp_in | input | 1 | External clamp input, asynchronous |
| cfg_place | input | 8 | Clocks from hsync trailing edge to clamp start |
| cfg_dur | input | 8 | Clamp window length in clocks |
| cfg_src_ext | input | 1 | 0 internal window, 1 external input |
| cfg_pol_ovr | input | 1 | 1 uses cfg_pol_high, 0 infers polarity |
| cfg_pol_high | input | 1 | External input active high when 1 |
| cfg_ofs_en | input | 1 | Enables the offset-update strobe |
| cfg_ofs_rate | input | 2 | Strobe rate select |
| clamp_out | output | 1 | Clamp active |
| ofs_strobe | output | 1 | Offset-update strobe |

## Verification
On every cycle, the embedded assertions check the strobe's width and its alignment with the falling edge of `clamp_out`, that a zero duration never opens a window, that a window ends only on count expiry or a restart, and that the inferred idle level changes only after a full run of equal samples. The absolute placement offset, the exact window length, the restart position, the polarity choices and the decimation counts for each rate depend on the configured values and on multi-line history. Only the bench's scenarios can show those.

// File: rtl/line_clamp_pkg.sv
package line_clamp_pkg;

    localparam int CNT_W = 8;

    localparam logic [CNT_W-1:0] PLACE_DEFAULT = 8'd8;
    localparam logic [CNT_W-1:0] DUR_DEFAULT   = 8'd32;
    localparam logic             POL_DEFAULT   = 1'b1;
    localparam logic [1:0]       RATE_DEFAULT  = 2'b11;
    localparam logic             OFS_EN_DEFAULT = 1'b0;

    typedef enum logic [1:0] {
        TS_IDLE  = 2'd0,
        TS_PLACE = 2'd1,
        TS_DUR   = 2'd2
    } timer_state_e;

    typedef enum logic [1:0] {
        RATE_EACH  = 2'b00,
        RATE_16    = 2'b01,
        RATE_64    = 2'b10,
        RATE_VSYNC = 2'b11
    } ofs_rate_e;

    typedef struct packed {
        logic [CNT_W-1:0] place;
        logic [CNT_W-1:0] dur;
        logic             src_ext;
        logic             pol_ovr;
        logic             pol_high;
        logic             ofs_en;
        ofs_rate_e        rate;
    } clamp_cfg_t;

    // windows per strobe for the counting rates
    function automatic logic [6:0] rate_period(input ofs_rate_e r);
        return (r == RATE_16) ? 7'd16 : 7'd64;
    endfunction

endpackage

// File: rtl/lcg_sync.sv
module lcg_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
        end else begin
            s1 <= d_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign lvl[i]  = s2[i];
        assign rise[i] = s2[i] & ~s3[i];
        assign fall[i] = ~s2[i] & s3[i];
    end
endmodule

// File: rtl/lcg_timer.sv
module lcg_timer
    import line_clamp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hs_fall,
    input  logic [CNT_W-1:0] place_i,
    input  logic [CNT_W-1:0] dur_i,
    output logic             win_o
);
    timer_state_e     st;
    logic [CNT_W-1:0] cnt;
    logic             in_dur;

    assign in_dur = (st == TS_DUR);
    assign win_o  = in_dur;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= TS_IDLE;
            cnt <= '0;
        end else if (hs_fall) begin
            if (dur_i == '0) begin
                st  <= TS_IDLE;
                cnt <= '0;
            end else if (place_i == '0) begin
                st  <= TS_DUR;
                cnt <= dur_i - 1'b1;
            end else begin
                st  <= TS_PLACE;
                cnt <= place_i - 1'b1;
            end
        end else begin
            unique case (st)
                TS_PLACE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (dur_i == '0) begin
                        st <= TS_IDLE;
                    end else begin
                        st  <= TS_DUR;
                        cnt <= dur_i - 1'b1;
                    end
                end
                TS_DUR: begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    else           st  <= TS_IDLE;
                end
                default: begin
                    st  <= TS_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end

    assert_win_end_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(in_dur) |-> ($past(cnt) == '0 || $past(hs_fall)));

    assert_zero_dur_R3: assert property (@(posedge clk) disable iff (rst)
        (dur_i == '0) |=> !$rose(in_dur));

    assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
        (hs_fall && place_i != '0 && dur_i != '0) |=> (st == TS_PLACE));
endmodule

// File: rtl/lcg_pol_detect.sv
module lcg_pol_detect #(
    parameter int IDLE_RUN = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic idle_o
);
    localparam int RW = $clog2(IDLE_RUN + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(IDLE_RUN);

    logic [RW-1:0] run;
    logic          prev;
    logic          idle;

    assign idle_o = idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= '0;
            prev <= 1'b0;
            idle <= 1'b0;
        end else begin
            prev <= lvl_i;
            if (lvl_i != prev) begin
                run <= '0;
            end else begin
                if (run != RUN_MAX) run <= run + 1'b1;
                if (run == RUN_MAX - 1'b1) idle <= lvl_i;
            end
        end
    end

    assert_idle_run_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(idle) |-> ($past(run) == RUN_MAX - 1'b1));
endmodule

// File: rtl/lcg_ofs_decim.sv
module lcg_ofs_decim
    import line_clamp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en_i,
    input  ofs_rate_e rate_i,
    input  logic      end_evt,
    input  logic      vs_rise,
    output logic      strobe_o
);
    logic [5:0] cnt;
    logic       pend;
    logic       qual;
    logic [6:0] period;

    assign period = rate_period(rate_i);

    always_comb begin
        unique case (rate_i)
            RATE_EACH:        qual = 1'b1;
            RATE_16, RATE_64: qual = ({1'b0, cnt} >= period - 7'd1);
            default:          qual = pend;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt      <= '0;
            pend     <= 1'b0;
            strobe_o <= 1'b0;
        end else begin
            strobe_o <= end_evt & qual;
            pend     <= vs_rise | (pend & ~end_evt);
            if (rate_i == RATE_16 || rate_i == RATE_64) begin
                if (end_evt) begin
                    if ({1'b0, cnt} >= period - 7'd1) cnt <= '0;
                    else                              cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end

    assert_off_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !strobe_o);

    assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, cnt} < period) || $past(rate_i != ofs_rate_e'(rate_i)) || (rate_i != $past(rate_i)));
endmodule

// File: rtl/line_clamp_gen.sv
module line_clamp_gen
    import line_clamp_pkg::*;
#(
    parameter int IDLE_RUN = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic             ext_clamp_in,
    input  logic [CNT_W-1:0] cfg_place,
    input  logic [CNT_W-1:0] cfg_dur,
    input  logic             cfg_src_ext,
    input  logic             cfg_pol_ovr,
    input  logic             cfg_pol_high,
    input  logic             cfg_ofs_en,
    input  logic [1:0]       cfg_ofs_rate,
    output logic             clamp_out,
    output logic             ofs_strobe
);
    localparam int NSYNC = 3;
    localparam int IX_HS = 0;
    localparam int IX_VS = 1;
    localparam int IX_EX = 2;

    clamp_cfg_t cfg;
    assign cfg = '{place: cfg_place, dur: cfg_dur, src_ext: cfg_src_ext,
                   pol_ovr: cfg_pol_ovr, pol_high: cfg_pol_high,
                   ofs_en: cfg_ofs_en, rate: ofs_rate_e'(cfg_ofs_rate)};

    logic [NSYNC-1:0] s_lvl, s_rise, s_fall;

    lcg_sync #(.W(NSYNC)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d_in ({ext_clamp_in, vsync_in, hsync_in}),
        .lvl  (s_lvl),
        .rise (s_rise),
        .fall (s_fall)
    );

    logic win_int;

    lcg_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .hs_fall (s_fall[IX_HS]),
        .place_i (cfg.place),
        .dur_i   (cfg.dur),
        .win_o   (win_int)
    );

    logic idle_lvl;

    lcg_pol_detect #(.IDLE_RUN(IDLE_RUN)) u_pol (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (s_lvl[IX_EX]),
        .idle_o (idle_lvl)
    );

    logic act_high, ext_act, clamp_nxt, clamp_q, end_evt;

    assign act_high  = cfg.pol_ovr ? cfg.pol_high : ~idle_lvl;
    assign ext_act   = act_high ? s_lvl[IX_EX] : ~s_lvl[IX_EX];
    assign clamp_nxt = cfg.src_ext ? ext_act : win_int;
    assign end_evt   = clamp_q & ~clamp_nxt;

    always_ff @(posedge clk) begin
        if (rst) clamp_q <= 1'b0;
        else     clamp_q <= clamp_nxt;
    end

    assign clamp_out = clamp_q;

    lcg_ofs_decim u_decim (
        .clk      (clk),
        .rst      (rst),
        .en_i     (cfg.ofs_en),
        .rate_i   (cfg.rate),
        .end_evt  (end_evt),
        .vs_rise  (s_rise[IX_VS]),
        .strobe_o (ofs_strobe)
    );

    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (rst)
        ofs_strobe |=> !ofs_strobe);

    assert_strobe_align_R9: assert property (@(posedge clk) disable iff (rst)
        ofs_strobe |-> (!clamp_out && $past(clamp_out)));

    assert_reset_quiet_R13: assert property (@(posedge clk)
        $past(rst) |-> (!clamp_out && !ofs_strobe));
endmodule

// File: tb/line_clamp_gen_bench.sv
module line_clamp_gen_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       hsync_in, vsync_in, ext_clamp_in;
    logic [7:0] cfg_place, cfg_dur;
    logic       cfg_src_ext, cfg_pol_ovr, cfg_pol_high, cfg_ofs_en;
    logic [1:0] cfg_ofs_rate;
    logic       clamp_out, ofs_strobe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    line_clamp_gen u_line_clamp_gen (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .ext_clamp_in(ext_clamp_in), .cfg_place(cfg_place), .cfg_dur(cfg_dur),
        .cfg_src_ext(cfg_src_ext), .cfg_pol_ovr(cfg_pol_ovr),
        .cfg_pol_high(cfg_pol_high), .cfg_ofs_en(cfg_ofs_en),
        .cfg_ofs_rate(cfg_ofs_rate), .clamp_out(clamp_out), .ofs_strobe(ofs_strobe)
    );

    // {place, dur}
    localparam logic [15:0] VEC [6] = '{
        {8'd8,   8'd32},
        {8'd0,   8'd1},
        {8'd1,   8'd1},
        {8'd5,   8'd3},
        {8'd200, 8'd40},
        {8'd3,   8'd0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hs_high(input int n);
        hsync_in = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // one short line, returns number of strobes seen
    task automatic short_line(output int got);
        got = 0;
        hs_high(4);
        hsync_in = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (ofs_strobe) got++;
        end
    endtask

    task automatic lines(input int n, output int total, output int last_got);
        int g;
        total = 0;
        last_got = 0;
        for (int i = 0; i < n; i++) begin
            short_line(g);
            total += g;
            last_got = g;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int first_hi, width, st_idx, st_cnt, tot, lastg, p, d;
        rst = 1'b1;
        hsync_in = 1'b1; vsync_in = 1'b0; ext_clamp_in = 1'b0;
        cfg_place = 8'd8; cfg_dur = 8'd32;
        cfg_src_ext = 1'b0; cfg_pol_ovr = 1'b0; cfg_pol_high = 1'b1;
        cfg_ofs_en = 1'b1; cfg_ofs_rate = 2'b00;
        repeat (5) @(negedge clk);
        chk(clamp_out == 1'b0, "R13 clamp in reset", clamp_out, 0);
        chk(ofs_strobe == 1'b0, "R13 strobe in reset", ofs_strobe, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(clamp_out == 1'b0 && ofs_strobe == 1'b0, "R13 after reset",
            {clamp_out, ofs_strobe}, 0);

        // table walk: R1 R2 R3 R9 R10
        foreach (VEC[v]) begin
            p = int'(VEC[v][15:8]);
            d = int'(VEC[v][7:0]);
            cfg_place = VEC[v][15:8];
            cfg_dur = VEC[v][7:0];
            hs_high(5);
            hsync_in = 1'b0;
            first_hi = -1; width = 0; st_idx = -1; st_cnt = 0;
            for (int k = 0; k < p + d + 10; k++) begin
                @(negedge clk);
                if (clamp_out) begin
                    width++;
                    if (first_hi < 0) first_hi = k;
                end
                if (ofs_strobe) begin
                    st_cnt++;
                    if (st_idx < 0) st_idx = k;
                end
            end
            if (d == 0) begin
                chk(width == 0, "R3 zero duration window", width, 0);
                chk(st_cnt == 0, "R3 zero duration strobe", st_cnt, 0);
            end else begin
                chk(first_hi == p + 3, "R1 placement", first_hi, p + 3);
                chk(width == d, "R2 duration", width, d);
                chk(st_idx == p + d + 3 && st_cnt == 1, "R9 R10 strobe position",
                    st_idx, p + d + 3);
            end
        end

        // R4 restart during placement
        cfg_place = 8'd10; cfg_dur = 8'd4;
        hs_high(5);
        hsync_in = 1'b0;
        first_hi = -1; width = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (clamp_out) begin width++; if (first_hi < 0) first_hi = k; end
            if (k == 5) hsync_in = 1'b1;
            if (k == 7) hsync_in = 1'b0;
        end
        chk(first_hi == 21, "R4 restart in placement start", first_hi, 21);
        chk(width == 4, "R4 restart in placement width", width, 4);

        // R4 restart during duration
        cfg_place = 8'd2; cfg_dur = 8'd20;
        hs_high(5);
        hsync_in = 1'b0;
        width = 0; tot = 0; lastg = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (clamp_out) width++;
            if (k == 17) tot = clamp_out;
            if (k == 18) lastg = clamp_out;
            if (k == 10) hsync_in = 1'b1;
            if (k == 12) hsync_in = 1'b0;
        end
        chk(tot == 0, "R4 restart drops clamp", tot, 0);
        chk(lastg == 1, "R4 restart new window", lastg, 1);
        chk(width == 31, "R4 restart total high", width, 31);

        // R8 disabled, then R11 every 16th counted from enable
        cfg_place = 8'd0; cfg_dur = 8'd1;
        cfg_ofs_en = 1'b0; cfg_ofs_rate = 2'b00;
        lines(20, tot, lastg);
        chk(tot == 0, "R8 disabled strobe", tot, 0);
        cfg_ofs_rate = 2'b01;
        cfg_ofs_en = 1'b1;
        lines(15, tot, lastg);
        chk(tot == 0, "R11 rate16 first 15", tot, 0);
        lines(1, tot, lastg);
        chk(tot == 1, "R11 rate16 16th", tot, 1);
        lines(16, tot, lastg);
        chk(tot == 1 && lastg == 1, "R11 rate16 next 16", tot, 1);

        // R11 every 64th
        cfg_ofs_en = 1'b0;
        @(negedge clk);
        cfg_ofs_rate = 2'b10;
        cfg_ofs_en = 1'b1;
        lines(63, tot, lastg);
        chk(tot == 0, "R11 rate64 first 63", tot, 0);
        lines(1, tot, lastg);
        chk(tot == 1, "R11 rate64 64th", tot, 1);

        // R12 vsync rate
        cfg_ofs_rate = 2'b11;
        lines(5, tot, lastg);
        chk(tot == 0, "R12 no vsync", tot, 0);
        vsync_in = 1'b1;
        repeat (4) @(negedge clk);
        vsync_in = 1'b0;
        lines(1, tot, lastg);
        chk(tot == 1, "R12 first line after vsync", tot, 1);
        lines(4, tot, lastg);
        chk(tot == 0, "R12 later lines", tot, 0);

        // R5 R6 external with forced polarity
        cfg_src_ext = 1'b1; cfg_pol_ovr = 1'b1; cfg_pol_high = 1'b1;
        ext_clamp_in = 1'b0;
        repeat (4) @(negedge clk);
        ext_clamp_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(clamp_out == 1'b0, "R5 latency before edge 2", clamp_out, 0);
        @(negedge clk);
        chk(clamp_out == 1'b1, "R5 R6 active high follows", clamp_out, 1);
        cfg_pol_high = 1'b0;
        @(negedge clk);
        chk(clamp_out == 1'b0, "R6 active low input high", clamp_out, 0);
        ext_clamp_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(clamp_out == 1'b1, "R6 active low input low", clamp_out, 1);

        // R7 inferred polarity
        cfg_pol_ovr = 1'b0;
        ext_clamp_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(clamp_out == 1'b0, "R7 low idle after reset", clamp_out, 0);
        ext_clamp_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(clamp_out == 1'b1, "R7 high active", clamp_out, 1);
        repeat (600) @(negedge clk);
        chk(clamp_out == 1'b0, "R7 high becomes idle", clamp_out, 0);
        ext_clamp_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(clamp_out == 1'b1, "R7 low now active", clamp_out, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule